// File: doc/BRIEF.md
# FFT Output Bin Reorder

This block sits behind a radix-2 FFT whose bins leave the transform in bit-reversed index order. It collects one complete frame of complex bins and then plays the frame back in a chosen order. It can play the frame back unchanged, in natural bin order (0 Hz first, then the positive bins, then the negative bins), or in centered order. Centered order rises strictly in frequency: the most negative bin comes first, 0 Hz sits in the middle and the highest positive bin comes last. Two frame banks alternate between writing and reading, so a continuous input stream gives a continuous output stream, one bin per clock.

The frame length is 2^`LOG2_N` bins. Two parameters fix the order. `REORDER_EN` turns the bit-reversal undo on. `SHIFT_EN` adds the centering, and it may only be set together with `REORDER_EN`; any other combination stops elaboration with an error. Inputs carry valid, sync, start-of-packet and end-of-packet markers, and so do the outputs. A sync pulse comes one cycle ahead of the first sample of its frame, and the block keeps that spacing at the output.

Top module: `fft_bin_reorder`

## Requirements
- R1: After reset, and until the first frame has been fully written, out_valid, out_sync, out_sop and out_eop are low, and out_re and out_im are zero.
- R2: With REORDER_EN=1 and SHIFT_EN=0, output position p of a frame carries the sample that arrived at position bitrev(p), where bitrev reverses the LOG2_N index bits.
- R3: With REORDER_EN=1 and SHIFT_EN=1, output position p carries the sample that arrived at position bitrev(p XOR N/2). N/2 is the top index bit, so the output starts with bin N/2 and 0 Hz appears at position N/2.
- R4: With REORDER_EN=0, output position p carries the sample that arrived at position p.
- R5: If the last sample of a frame is captured at clock edge e, output position p is presented after edge e+2+p. The N bins of a frame come out on N consecutive cycles.
- R6: out_sop is high only with the first bin of a frame, and out_eop only with the last bin. Neither is ever high without out_valid.
- R7: out_sync is high for one cycle, right after edge e+1, when the frame was preceded by an in_sync pulse. An in_sync pulse counts when it came in the same cycle as, or after, the last valid sample before the frame's first sample. For any other frame out_sync stays low.
- R8: Input frames that arrive back to back with no idle cycle come out back to back with no idle cycle, and frame bank use never collides.
- R9: Cycles with in_valid low leave the frame contents unchanged, whatever in_re and in_im carry; the samples around the gap still land at consecutive positions.
- R10: A valid sample with in_sop high starts a new frame at position 0 in the current bank. Any partial frame written so far is thrown away and never appears at the output. in_eop is expected only on the N-th sample of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_sync | input | 1 | Sync pulse, one cycle before a frame's first sample |
| in_sop | input | 1 | First sample of a frame |
| in_eop | input | 1 | Last sample of a frame |
| in_re | input | DAT_W | Real part of the input bin |
| in_im | input | DAT_W | Imaginary part of the input bin |
| out_valid | output | 1 | Output bin valid |
| out_sync | output | 1 | Sync pulse, one cycle before out_sop |
| out_sop | output | 1 | First output bin of a frame |
| out_eop | output | 1 | Last output bin of a frame |
| out_re | output | DAT_W | Real part of the output bin |
| out_im | output | DAT_W | Imaginary part of the output bin |

## Verification
Every output result is tied to the clock edge that captured the frame's last input sample, edge e. The sync pulse is due after edge e+1 and bin p after edge e+2+p, whether the input frame had gaps or not. The bench records e for each frame when it drives the last sample. A counter that advances on rising edges then lets the monitor, sampling on falling edges, compare each output bin against its exact due cycle as well as against the stored arrival data. Three instances (unchanged, natural and centered order) see the same stimulus, so each mapping is checked on frames with gaps, on back-to-back frames and on a frame restarted after an aborted partial frame.

// File: rtl/fft_reorder_pkg.sv
package fft_reorder_pkg;

  // Read-side ordering selected at elaboration
  typedef enum logic [1:0] {
    ORDER_RAW      = 2'd0,  // emit in arrival order
    ORDER_NATURAL  = 2'd1,  // undo bit reversal
    ORDER_CENTERED = 2'd2   // undo bit reversal and centre 0 Hz
  } order_mode_e;

  function automatic order_mode_e pick_order(input bit reorder, input bit shift);
    if (!reorder)   return ORDER_RAW;
    else if (shift) return ORDER_CENTERED;
    else            return ORDER_NATURAL;
  endfunction

endpackage

// File: rtl/reorder_wr_ctrl.sv
module reorder_wr_ctrl #(
  parameter int LOG2_N = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              wr_en,
  output logic [LOG2_N:0]   wr_addr,
  output logic              frame_done,
  output logic [1:0]        bank_sync
);

  localparam logic [LOG2_N-1:0] IDX_LAST = '1;

  logic [LOG2_N-1:0] wr_idx_q, wr_idx_n;
  logic              wr_bank_q, wr_bank_n;
  logic              sync_pend_q, sync_pend_n;
  logic [1:0]        bank_sync_q, bank_sync_n;
  logic [LOG2_N-1:0] cur_idx;
  logic              last_smp;

  // Position of the sample on the inputs this cycle
  always_comb begin
    cur_idx  = in_sop ? '0 : wr_idx_q;
    last_smp = in_valid && (cur_idx == IDX_LAST);
  end

  assign wr_en      = in_valid;
  assign wr_addr    = {wr_bank_q, cur_idx};
  assign frame_done = last_smp;
  assign bank_sync  = bank_sync_q;

  // Next-state logic
  always_comb begin
    wr_idx_n    = wr_idx_q;
    wr_bank_n   = wr_bank_q;
    sync_pend_n = sync_pend_q;
    bank_sync_n = bank_sync_q;
    if (in_valid) begin
      wr_idx_n = last_smp ? '0 : cur_idx + 1'b1;
      if (cur_idx == '0) bank_sync_n[wr_bank_q] = sync_pend_q;
    end
    if (last_smp) wr_bank_n = ~wr_bank_q;
    if (in_sync)       sync_pend_n = 1'b1;
    else if (in_valid) sync_pend_n = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q    <= '0;
      wr_bank_q   <= 1'b0;
      sync_pend_q <= 1'b0;
      bank_sync_q <= '0;
    end else begin
      wr_idx_q    <= wr_idx_n;
      wr_bank_q   <= wr_bank_n;
      sync_pend_q <= sync_pend_n;
      bank_sync_q <= bank_sync_n;
    end
  end

  // R10: end-of-packet only on the N-th sample of a frame
  p_in_eop_on_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && !in_sop) |-> (wr_idx_q == IDX_LAST))
    else $error("in_eop away from the last frame position");

endmodule

// File: rtl/reorder_rd_ctrl.sv
module reorder_rd_ctrl
  import fft_reorder_pkg::*;
#(
  parameter int          LOG2_N = 10,
  parameter order_mode_e MODE   = ORDER_NATURAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_done,
  input  logic [1:0]      bank_sync,
  output logic            rd_en,
  output logic [LOG2_N:0] rd_addr,
  output logic            dat_load,
  output logic            out_valid,
  output logic            out_sync,
  output logic            out_sop,
  output logic            out_eop
);

  localparam logic [LOG2_N-1:0] IDX_LAST = '1;
  localparam logic [LOG2_N-1:0] IDX_MSB  = {1'b1, {(LOG2_N-1){1'b0}}};

  logic [LOG2_N-1:0] rd_cnt_q, rd_cnt_n;
  logic              rd_bank_q, rd_bank_n;
  logic              rd_active_q, rd_active_n;
  logic [1:0]        pend_q, pend_n;
  logic              s1_valid_q, s1_sop_q, s1_eop_q;
  logic              ov_q, os_q, osop_q, oeop_q;
  logic              start, issue, cnt_last;
  logic [LOG2_N-1:0] bin_idx, map_idx;

  always_comb begin
    start    = (pend_q != 2'd0) && !rd_active_q;
    issue    = rd_active_q || start;
    cnt_last = (rd_cnt_q == IDX_LAST);
  end

  // Bin selected for this output position
  generate
    if (MODE == ORDER_CENTERED) begin : g_centered
      assign bin_idx = rd_cnt_q ^ IDX_MSB;
    end else begin : g_straight
      assign bin_idx = rd_cnt_q;
    end
  endgenerate

  // Bin to buffer position (arrival order is bit reversed)
  generate
    if (MODE == ORDER_RAW) begin : g_no_reverse
      assign map_idx = bin_idx;
    end else begin : g_reverse
      always_comb begin
        for (int b = 0; b < LOG2_N; b++) map_idx[b] = bin_idx[LOG2_N-1-b];
      end
    end
  endgenerate

  assign rd_en    = issue;
  assign rd_addr  = {rd_bank_q, map_idx};
  assign dat_load = s1_valid_q;

  // Next-state logic
  always_comb begin
    rd_cnt_n    = rd_cnt_q;
    rd_bank_n   = rd_bank_q;
    rd_active_n = issue && !cnt_last;
    pend_n      = pend_q + {1'b0, frame_done} - {1'b0, start};
    if (issue) begin
      rd_cnt_n = cnt_last ? '0 : rd_cnt_q + 1'b1;
      if (cnt_last) rd_bank_n = ~rd_bank_q;
    end
  end

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q    <= '0;
      rd_bank_q   <= 1'b0;
      rd_active_q <= 1'b0;
      pend_q      <= '0;
    end else begin
      rd_cnt_q    <= rd_cnt_n;
      rd_bank_q   <= rd_bank_n;
      rd_active_q <= rd_active_n;
      pend_q      <= pend_n;
    end
  end

  // Marker pipeline: stage 1 beside the RAM read, stage 2 at the outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_sop_q   <= 1'b0;
      s1_eop_q   <= 1'b0;
      ov_q       <= 1'b0;
      os_q       <= 1'b0;
      osop_q     <= 1'b0;
      oeop_q     <= 1'b0;
    end else begin
      s1_valid_q <= issue;
      s1_sop_q   <= issue && (rd_cnt_q == '0);
      s1_eop_q   <= issue && cnt_last;
      os_q       <= issue && (rd_cnt_q == '0) && bank_sync[rd_bank_q];
      ov_q       <= s1_valid_q;
      osop_q     <= s1_sop_q;
      oeop_q     <= s1_eop_q;
    end
  end

  assign out_valid = ov_q;
  assign out_sync  = os_q;
  assign out_sop   = osop_q;
  assign out_eop   = oeop_q;

  // R8: a full frame never waits behind another waiting frame
  p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 2'd1)
    else $error("more than one frame waiting for readout");

endmodule

// File: rtl/reorder_pp_ram.sv
module reorder_pp_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data_q <= mem_q[rd_addr];
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/fft_bin_reorder.sv
module fft_bin_reorder
  import fft_reorder_pkg::*;
#(
  parameter int LOG2_N     = 10,
  parameter int DAT_W      = 16,
  parameter bit REORDER_EN = 1'b1,
  parameter bit SHIFT_EN   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sync,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [DAT_W-1:0] in_re,
  input  logic [DAT_W-1:0] in_im,
  output logic             out_valid,
  output logic             out_sync,
  output logic             out_sop,
  output logic             out_eop,
  output logic [DAT_W-1:0] out_re,
  output logic [DAT_W-1:0] out_im
);

  localparam order_mode_e MODE = pick_order(REORDER_EN, SHIFT_EN);
  localparam int          AW   = LOG2_N + 1;
  localparam int          PW   = 2 * DAT_W;

  // Illegal configurations stop elaboration
  generate
    if (SHIFT_EN && !REORDER_EN) begin : g_bad_mode
      $error("centered order needs bit-reversal undo enabled");
    end
    if (LOG2_N < 1) begin : g_bad_size
      $error("frame length must be at least two bins");
    end
  endgenerate

  logic          wr_en, frame_done, rd_en, dat_load;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [1:0]    bank_sync;
  logic [PW-1:0] rd_data;
  logic [PW-1:0] out_dat_q;
  logic          ov, os, osop, oeop;

  reorder_wr_ctrl #(.LOG2_N(LOG2_N)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sync    (in_sync),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frame_done (frame_done),
    .bank_sync  (bank_sync)
  );

  reorder_pp_ram #(.ADDR_W(AW), .DATA_W(PW)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data ({in_re, in_im}),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  reorder_rd_ctrl #(.LOG2_N(LOG2_N), .MODE(MODE)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .bank_sync  (bank_sync),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .dat_load   (dat_load),
    .out_valid  (ov),
    .out_sync   (os),
    .out_sop    (osop),
    .out_eop    (oeop)
  );

  // Output data register, loaded only with a fresh RAM word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_dat_q <= '0;
    else if (dat_load) out_dat_q <= rd_data;
  end

  assign out_valid = ov;
  assign out_sync  = os;
  assign out_sop   = osop;
  assign out_eop   = oeop;
  assign out_re    = out_dat_q[PW-1:DAT_W];
  assign out_im    = out_dat_q[DAT_W-1:0];

  // R8: writer and reader never touch the same buffer word at once
  p_no_bank_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_addr != rd_addr))
    else $error("write and read collide in frame buffer");

  // R6: packet markers only with valid bins
  p_sop_eop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid)
    else $error("marker without valid");

  // R7: sync is followed by the first bin
  p_sync_then_sop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |=> (out_sop && out_valid))
    else $error("out_sync not followed by out_sop");

  // R5: bins of a frame are contiguous
  p_frame_contiguous_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> out_valid)
    else $error("gap inside an output frame");

endmodule

// File: tb/fft_bin_reorder_tb.sv
`timescale 1ns/1ps
module fft_bin_reorder_tb;

  localparam int LG   = 5;
  localparam int N    = 1 << LG;
  localparam int DW   = 12;
  localparam int MAXF = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          in_valid, in_sync, in_sop, in_eop;
  logic [DW-1:0] in_re, in_im;

  logic          o_valid [3];
  logic          o_sync  [3];
  logic          o_sop   [3];
  logic          o_eop   [3];
  logic [DW-1:0] o_re    [3];
  logic [DW-1:0] o_im    [3];

  // 0: natural order, 1: centered order, 2: arrival order
  fft_bin_reorder #(.LOG2_N(LG), .DAT_W(DW), .REORDER_EN(1'b1), .SHIFT_EN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .in_sop(in_sop),
    .in_eop(in_eop), .in_re(in_re), .in_im(in_im), .out_valid(o_valid[0]), .out_sync(o_sync[0]),
    .out_sop(o_sop[0]), .out_eop(o_eop[0]), .out_re(o_re[0]), .out_im(o_im[0]));

  fft_bin_reorder #(.LOG2_N(LG), .DAT_W(DW), .REORDER_EN(1'b1), .SHIFT_EN(1'b1)) u_dut_ctr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .in_sop(in_sop),
    .in_eop(in_eop), .in_re(in_re), .in_im(in_im), .out_valid(o_valid[1]), .out_sync(o_sync[1]),
    .out_sop(o_sop[1]), .out_eop(o_eop[1]), .out_re(o_re[1]), .out_im(o_im[1]));

  fft_bin_reorder #(.LOG2_N(LG), .DAT_W(DW), .REORDER_EN(1'b0), .SHIFT_EN(1'b0)) u_dut_raw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .in_sop(in_sop),
    .in_eop(in_eop), .in_re(in_re), .in_im(in_im), .out_valid(o_valid[2]), .out_sync(o_sync[2]),
    .out_sop(o_sop[2]), .out_eop(o_eop[2]), .out_re(o_re[2]), .out_im(o_im[2]));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [2*DW-1:0] exp_dat [MAXF][N];
  int              exp_last [MAXF];
  bit              exp_sync [MAXF];
  string           exp_tag  [MAXF];
  int              nfr = 0;

  int rf [3] = '{0, 0, 0};
  int rp [3] = '{0, 0, 0};
  bit sync_seen [3] = '{1'b0, 1'b0, 1'b0};

  function automatic int brev(input int v);
    int r = 0;
    for (int b = 0; b < LG; b++) if (v[b]) r |= (1 << (LG - 1 - b));
    return r;
  endfunction

  function automatic int src_pos(input int mode, input int p);
    case (mode)
      0:       return brev(p);
      1:       return brev(p ^ (N / 2));
      default: return p;
    endcase
  endfunction

  function automatic string mode_req(input int mode);
    case (mode)
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Output monitor, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 3; m++) begin
        if (o_sync[m]) begin
          // R7: sync pulse only for a synced frame, one cycle before its first bin
          if (rf[m] < nfr)
            check(rp[m] == 0 && exp_sync[rf[m]] && cyc == exp_last[rf[m]] + 1,
                  "R7 sync timing", cyc, exp_last[rf[m]] + 1);
          else
            check(1'b0, "R7 sync without frame", 1, 0);
          sync_seen[m] = 1'b1;
        end
        if (o_valid[m]) begin
          if (rf[m] >= nfr) begin
            check(1'b0, "R1 valid before any full frame", 1, 0);
          end else begin
            check({o_re[m], o_im[m]} == exp_dat[rf[m]][src_pos(m, rp[m])],
                  {mode_req(m), " data ", exp_tag[rf[m]]},
                  {o_re[m], o_im[m]}, exp_dat[rf[m]][src_pos(m, rp[m])]);
            check(cyc == exp_last[rf[m]] + 2 + rp[m], "R5 bin timing",
                  cyc, exp_last[rf[m]] + 2 + rp[m]);
            check(o_sop[m] == (rp[m] == 0) && o_eop[m] == (rp[m] == N - 1), "R6 markers",
                  {o_sop[m], o_eop[m]}, {rp[m] == 0, rp[m] == N - 1});
            if (rp[m] == 0) begin
              check(sync_seen[m] == exp_sync[rf[m]], "R7 sync presence",
                    sync_seen[m], exp_sync[rf[m]]);
              sync_seen[m] = 1'b0;
            end
            rp[m]++;
            if (rp[m] == N) begin
              rp[m] = 0;
              rf[m]++;
            end
          end
        end else if (o_sop[m] || o_eop[m]) begin
          check(1'b0, "R6 marker without valid", {o_sop[m], o_eop[m]}, 0);
        end
      end
    end
  end

  task automatic put(input bit v, input bit sy, input bit sp, input bit ep,
                     input logic [2*DW-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_sync  = sy;
    in_sop   = sp;
    in_eop   = ep;
    in_re    = d[2*DW-1:DW];
    in_im    = d[DW-1:0];
  endtask

  // R9: idle cycles carry garbage data that must not land in a frame
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 1'b0, $urandom);
  endtask

  task automatic send_frame(input bit with_sync, input int gap_pct, input bit ramp,
                            input string tag);
    logic [2*DW-1:0] d;
    if (with_sync) put(1'b0, 1'b1, 1'b0, 1'b0, $urandom);
    for (int i = 0; i < N; i++) begin
      while (i > 0 && ($urandom % 100) < gap_pct) put(1'b0, 1'b0, 1'b0, 1'b0, $urandom);
      d = ramp ? {DW'(i), ~DW'(i)} : (2*DW)'($urandom);
      exp_dat[nfr][i] = d;
      put(1'b1, 1'b0, i == 0, i == N - 1, d);
    end
    exp_last[nfr] = cyc + 1;
    exp_sync[nfr] = with_sync;
    exp_tag[nfr]  = tag;
    nfr++;
  endtask

  // R10: partial frame started by sop and never completed
  task automatic send_partial(input int len);
    for (int i = 0; i < len; i++) put(1'b1, 1'b0, i == 0, 1'b0, $urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0; in_sync = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_re = '0; in_im = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      idle(1);
      for (int m = 0; m < 3; m++)
        check(!o_valid[m] && !o_sync[m] && !o_sop[m] && !o_eop[m] && o_re[m] == '0 && o_im[m] == '0,
              "R1 reset state", {o_valid[m], o_sync[m], o_sop[m], o_eop[m], o_re[m], o_im[m]}, 0);
    end
    send_frame(1'b1, 0, 1'b1, "ramp R5");
    idle(3);
    send_frame(1'b0, 35, 1'b0, "gappy R9");
    idle(2);
    send_partial(11);
    send_frame(1'b1, 0, 1'b0, "restart R10");
    send_partial(N - 1);
    send_frame(1'b0, 10, 1'b0, "restart R10");
    for (int k = 0; k < 8; k++) send_frame(k % 3 == 0, 0, 1'b0, "back-to-back R8");
    for (int k = 0; k < 6; k++) send_frame(1'($urandom % 2), 20, 1'b0, "random R9");
    idle(3 * N);
    for (int m = 0; m < 3; m++)
      check(rf[m] == nfr && rp[m] == 0, "R10 frame count", rf[m], nfr);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule